// File: doc/BRIEF.md
# Parallel I/O Port Pair with Edge-Triggered Interrupt

This block gives a host two parallel ports, A and B, each `W` bits wide (8 by default). Every pin has an output bit and a direction bit. The host reaches both through a small register bus. Every clock cycle with `cs` high is one access: `wr` chooses write or read, and a read returns its data combinationally on `rdata` in that same cycle. Pins are modelled as separate input, output and output-enable vectors. No pad logic is included.

The top pin of port A (bit `W-1`) feeds an edge detector. Both the detector's polarity and its interrupt enable come from address bits during a write, so the data bus plays no part in that write. A detected edge sets a sticky flag. The flag is exported on `edge_flag` so that a shared status register can collect it. When the interrupt is enabled, the flag also pulls `irq_n` low. Reading the flag register clears the flag.

Top module: `pio_edge_port`

## Requirements
- R1: After reset, every output bit and direction bit is 0, so all pins are inputs with `pa_oe`/`pb_oe` = 0 and `pa_out`/`pb_out` = 0. The edge enable, the polarity and the flag are also 0, which leaves `irq_n` = 1 and `edge_flag` = 0.
- R2: With `cs`=1, `rsel`=1 and `addr[2]`=0, `addr[1:0]` selects a port register: 00 is A output, 01 is A direction, 10 is B output and 11 is B direction. A write with `cs`=0 changes nothing.
- R3: `pa_out`/`pb_out` equal the port's output register and `pa_oe`/`pb_oe` equal its direction register. A direction bit of 1 makes that pin an output.
- R4: A read of a direction register returns that register. A read of a data register returns `(out & dir) | (pin_sync & ~dir)`. A pin change made before clock edge k is visible in a read from the cycle after edge k+1 onward, and not in the cycle between edges k and k+1.
- R5: A write with `rsel`=1, `addr[2]`=1 and `addr[4]`=0 loads the edge enable from `addr[1]` and the polarity from `addr[0]` (1 = rising), whatever `wdata` holds. A write with `addr[4]`=1 leaves both unchanged.
- R6: A change of the synchronised pin A bit `W-1` in the selected direction sets the flag on the third clock edge after the pin change, whether the interrupt is enabled or not. A change in the other direction does not set the flag.
- R7: A read with `rsel`=1, `addr[2]`=1 and `addr[0]`=1 returns the flag in bit 6 and 0 in all other bits. The flag clears at the edge that ends the read, except when an edge is detected at that same clock edge; in that case the flag is set.
- R8: `irq_n` is 0 exactly when the flag is set and the edge interrupt is enabled, and `edge_flag` always shows the flag.
- R9: `rdata` is 0 for reads with `rsel`=0, for reads with `addr[2]`=1 and `addr[0]`=0, and in every cycle where `cs`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access strobe, one access per cycle |
| rsel | input | 1 | 1 = I/O and edge registers, 0 = unmapped space |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Register address bits |
| wdata | input | W | Write data |
| rdata | output | W | Read data, valid in the read cycle |
| pa_in | input | W | Port A pin inputs (asynchronous) |
| pa_out | output | W | Port A output values |
| pa_oe | output | W | Port A output enables |
| pb_in | input | W | Port B pin inputs (asynchronous) |
| pb_out | output | W | Port B output values |
| pb_oe | output | W | Port B output enables |
| irq_n | output | 1 | Active-low edge interrupt |
| edge_flag | output | 1 | Edge flag for a shared status register |

## Verification
The embedded properties assume two things. First, bus inputs hold steady across the clock edge that closes each access. Second, pin inputs are the only asynchronous signals, so the detector sees them only through the synchroniser. The bench drives every bus field and pin change on the falling clock edge and samples `rdata` and the pins one time unit later, so no input moves near a rising edge. Pin changes for edge tests are followed by at least four idle cycles before the flag is examined, except in the single test that deliberately lines an edge up with a clearing read.

// File: rtl/pio_edge_port.sv
module pio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rsel,
  input  logic         wr,
  input  logic [4:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  output logic         irq_n,
  output logic         edge_flag
);
  localparam int TOP  = W - 1;
  localparam int FBIT = 6;

  logic [W-1:0] a_dat, a_dir, b_dat, b_dir;
  logic [W-1:0] a_s1, a_s2, b_s1, b_s2;
  logic         a_prev, en_q, pos_q, flag_q;
  logic [1:0]   warm;
  logic [W-1:0] rd_v;

  wire unused_a3 = addr[3];

  wire port_wr = cs & rsel & ~addr[2] & wr;
  wire ctl_wr  = cs & rsel & addr[2] & ~addr[4] & wr;
  wire flag_rd = cs & rsel & addr[2] & addr[0] & ~wr;
  wire armed   = (warm == 2'd3);
  wire hit     = armed & (pos_q ? (a_s2[TOP] & ~a_prev) : (~a_s2[TOP] & a_prev));

  assign pa_out    = a_dat;
  assign pa_oe     = a_dir;
  assign pb_out    = b_dat;
  assign pb_oe     = b_dir;
  assign edge_flag = flag_q;
  assign irq_n     = ~(flag_q & en_q);
  assign rdata     = rd_v;

  always_comb begin
    rd_v = '0;
    if (cs && !wr && rsel) begin
      if (!addr[2]) begin
        case (addr[1:0])
          2'd0:    rd_v = (a_dat & a_dir) | (a_s2 & ~a_dir);
          2'd1:    rd_v = a_dir;
          2'd2:    rd_v = (b_dat & b_dir) | (b_s2 & ~b_dir);
          default: rd_v = b_dir;
        endcase
      end else if (addr[0]) begin
        rd_v[FBIT] = flag_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_dat <= '0; a_dir <= '0; b_dat <= '0; b_dir <= '0;
      a_s1  <= '0; a_s2  <= '0; b_s1  <= '0; b_s2  <= '0;
      a_prev <= 1'b0; en_q <= 1'b0; pos_q <= 1'b0; flag_q <= 1'b0;
      warm <= 2'd0;
    end else begin
      a_s1   <= pa_in;
      a_s2   <= a_s1;
      b_s1   <= pb_in;
      b_s2   <= b_s1;
      a_prev <= a_s2[TOP];
      if (!armed) warm <= warm + 2'd1;
      if (port_wr) begin
        case (addr[1:0])
          2'd0:    a_dat <= wdata;
          2'd1:    a_dir <= wdata;
          2'd2:    b_dat <= wdata;
          default: b_dir <= wdata;
        endcase
      end
      if (ctl_wr) begin
        en_q  <= addr[1];
        pos_q <= addr[0];
      end
      if (hit)          flag_q <= 1'b1;
      else if (flag_rd) flag_q <= 1'b0;
    end
  end

  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rsel && wr && !addr[2] && addr[0]) |=> $stable({pa_oe, pb_oe}));

  a_r5_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (en_q == $past(addr[1])) && (pos_q == $past(addr[0])));

  a_r5_ctl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({en_q, pos_q}));

  a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> edge_flag);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !hit) |=> !edge_flag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !flag_rd) |=> edge_flag);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> edge_flag);
endmodule

// File: tb/test_pio_edge_port.sv
module test_pio_edge_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rsel = 1'b0, wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic       irq_n, edge_flag;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pio_edge_port #(.W(8)) i_pio_edge_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .irq_n(irq_n), .edge_flag(edge_flag)
  );

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic rs, input logic [4:0] a, input logic w,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cs = 1'b1; rsel = rs; addr = a; wr = w; wdata = d;
    #1 q = rdata;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q, da, ra, db, rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 edge_flag", {7'd0, edge_flag}, 8'h00);
    acc(1, 5'b00001, 0, 0, q); chk("R1 dirA read", q, 8'h00);

    // R2 R3 R4 register sweep with steady pins
    pa_in = 8'h3C; pb_in = 8'hC5;
    idle(3);
    for (int k = 0; k < 24; k++) begin
      da = 8'(k * 29 + 3); ra = 8'(k * 71 + 5);
      db = 8'(k * 113 + 17); rb = 8'(k * 47 + 90);
      acc(1, 5'b00000, 1, da, q);
      acc(1, 5'b00001, 1, ra, q);
      acc(1, 5'b00010, 1, db, q);
      acc(1, 5'b00011, 1, rb, q);
      chk("R3 pa_out", pa_out, da);
      chk("R3 pa_oe", pa_oe, ra);
      chk("R3 pb_out", pb_out, db);
      chk("R3 pb_oe", pb_oe, rb);
      acc(1, 5'b00001, 0, 8'hFF, q); chk("R2 dirA read", q, ra);
      acc(1, 5'b00011, 0, 8'hFF, q); chk("R2 dirB read", q, rb);
      acc(1, 5'b00000, 0, 8'hFF, q); chk("R4 dataA mix", q, (da & ra) | (pa_in & ~ra));
      acc(1, 5'b00010, 0, 8'hFF, q); chk("R4 dataB mix", q, (db & rb) | (pb_in & ~rb));
    end

    // R2 write with cs low ignored
    @(negedge clk);
    cs = 1'b0; rsel = 1'b1; wr = 1'b1; addr = 5'b00000; wdata = ~pa_out;
    da = pa_out;
    @(negedge clk); wr = 1'b0;
    #1 chk("R2 cs low write ignored", pa_out, da);

    // R4 pin latency
    acc(1, 5'b00001, 1, 8'h00, q);
    acc(1, 5'b00011, 1, 8'h00, q);
    pa_in = 8'h11; pb_in = 8'h22;
    idle(3);
    @(negedge clk); pa_in = 8'hE7; pb_in = 8'h9A;
    acc(1, 5'b00000, 0, 0, q); chk("R4 A not yet visible", q, 8'h11);
    acc(1, 5'b00010, 0, 0, q); chk("R4 B visible later", q, 8'h9A);
    @(negedge clk); pb_in = 8'h5B;
    @(negedge clk);
    acc(1, 5'b00010, 0, 0, q); chk("R4 B visible after two edges", q, 8'h5B);
    acc(1, 5'b00000, 0, 0, q); chk("R4 A visible", q, 8'hE7);

    // R9 unmapped reads
    acc(0, 5'b00000, 0, 0, q); chk("R9 rsel low read", q, 8'h00);
    acc(1, 5'b00100, 0, 0, q); chk("R9 A2 A0=0 read", q, 8'h00);
    @(negedge clk); cs = 1'b0; rsel = 1'b1; addr = 5'b00101; wr = 1'b0;
    #1 chk("R9 cs low rdata", rdata, 8'h00);

    // R5 R6 R7 R8 edge sweep
    for (int en = 0; en < 2; en++) begin
      for (int pol = 0; pol < 2; pol++) begin
        pa_in[7] = ~1'(pol);
        acc(1, {3'b001, 1'(en), 1'(pol)}, 1, 8'hA5, q);
        idle(4);
        acc(1, 5'b00101, 0, 0, q);
        chk("R6 idle flag clear", {7'd0, edge_flag}, 8'h00);
        chk("R8 idle irq_n", {7'd0, irq_n}, 8'h01);
        @(negedge clk); pa_in[7] = 1'(pol);
        idle(4);
        chk("R6 trigger edge sets flag", {7'd0, edge_flag}, 8'h01);
        chk("R8 R5 irq_n follows enable", {7'd0, irq_n}, {7'd0, ~1'(en)});
        acc(1, 5'b00101, 0, 0, q); chk("R7 flag read value", q, 8'h40);
        chk("R7 flag cleared", {7'd0, edge_flag}, 8'h00);
        chk("R8 irq_n released", {7'd0, irq_n}, 8'h01);
        acc(1, 5'b00101, 0, 0, q); chk("R7 second read", q, 8'h00);
        @(negedge clk); pa_in[7] = ~1'(pol);
        idle(4);
        chk("R6 opposite edge ignored", {7'd0, edge_flag}, 8'h00);
      end
    end

    // R5 write with addr[4]=1 ignored
    acc(1, 5'b00111, 1, 8'h00, q);
    pa_in[7] = 1'b0; idle(4);
    acc(1, 5'b00101, 0, 0, q);
    @(negedge clk); pa_in[7] = 1'b1;
    idle(4);
    chk("R8 irq low when enabled", {7'd0, irq_n}, 8'h00);
    acc(1, 5'b10100, 1, 8'hFF, q);
    #1 chk("R5 A4 write keeps enable", {7'd0, irq_n}, 8'h00);
    acc(1, 5'b00101, 0, 0, q);
    @(negedge clk); pa_in[7] = 1'b0;
    idle(4);
    chk("R5 A4 write keeps polarity", {7'd0, edge_flag}, 8'h00);

    // R7 edge coinciding with clearing read
    @(negedge clk); pa_in[7] = 1'b1;
    @(negedge clk);
    acc(1, 5'b00101, 0, 0, q);
    chk("R7 read before edge", q, 8'h00);
    chk("R7 set wins over clear", {7'd0, edge_flag}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule